// File: doc/BRIEF.md
# Pipelined Deblocking Edge Filter

This block smooths one line of eight 8-bit samples that straddles a block edge in a decoded video picture. Four samples lie on the near side of the edge (p3 farthest, p0 nearest) and four on the far side (q0 nearest, q3 farthest). Each line arrives with a boundary strength, the alpha and beta gradient thresholds and a clipping value, all produced elsewhere from the quantizer. It also carries a flag that marks the line as luma or chroma. The block returns the line with its samples either corrected or passed through unchanged.

The datapath is a five-stage pipeline: capture, threshold decision, pre-filter, secondary filter and write-back. It takes one new line on every clock and never stalls. All filter taps are built from shifts and two-input additions. The partial sums formed in the pre-filter stage are reused by the strong 3-, 4- and 5-tap filters and by the normal filter. Edge ordering, threshold table lookup and memory addressing belong to the surrounding logic.

Top module: `dbf_edge_pipe`

## Requirements
- R1: Line layout is p3 in bits [7:0], p2 [15:8], p1 [23:16], p0 [31:24], q0 [39:32], q1 [47:40], q2 [55:48], q3 [63:56]. A boundary strength of 0 returns all eight samples unchanged.
- R2: No sample changes unless all three gradient tests hold: |p0−q0|<alpha, |p1−p0|<beta and |q1−q0|<beta.
- R3: For strength 1 to 3, delta = clip(±tc, ((q0−p0)·4 + (p1−q1) + 4) >> 3) with an arithmetic shift. The new p0 is p0+delta and the new q0 is q0−delta, each saturated to 0..255.
- R4: For strength 1 to 3 on luma, p1 becomes p1 + clip(±C1, (p2 + ((p0+q0+1)>>1) − 2·p1) >> 1) only when |p2−p0|<beta. q1 is treated the same way using the q-side samples. p2 and q2 are never changed.
- R5: tc equals C1 plus one for each luma side whose flatness test (|p2−p0|<beta, |q2−q0|<beta) holds. On chroma, tc is C1+1.
- R6: For strength 4 on luma, a side that is flat and has |p0−q0| < (alpha>>2)+2 takes new values p0=(p2+2p1+2p0+2q0+q1+4)>>3, p1=(p2+p1+p0+q0+2)>>2 and p2=(2p3+3p2+p1+p0+q0+4)>>3. The q side is handled the same way with the roles mirrored.
- R7: For strength 4, a side that fails its strong condition changes only its nearest sample, to (2p1+p0+q1+2)>>2 (mirrored for q).
- R8: For chroma lines, only p0 and q0 may change, for every nonzero strength. Strength 4 uses the 3-tap formula of R7.
- R9: out_valid follows in_valid exactly five clocks later, one line per clock, and p3 and q3 always pass through unchanged.
- R10: Strength codes 5 to 7 behave as strength 4.
- R11: While rst_n is low at a clock edge, out_valid and out_line are cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A line is presented this cycle |
| in_line | input | 64 | Eight samples, layout per R1 |
| in_bs | input | 3 | Boundary strength |
| in_alpha | input | 8 | Edge gradient threshold |
| in_beta | input | 8 | Side gradient threshold |
| in_c1 | input | 5 | Clipping value C1 |
| in_chroma | input | 1 | 1 = chroma line, 0 = luma |
| out_valid | output | 1 | Filtered line valid |
| out_line | output | 64 | Filtered samples, same layout |

## Verification
The bench targets gradients that sit exactly at alpha or beta. A design that uses "less than or equal" in these tests would filter lines that must pass untouched. It also drives strong-strength luma lines where one side is flat and the other is not. A design that shares the strong decision across both sides would rewrite p1 and p2 on the rough side. Chroma lines at strength 4 and strength codes 5 to 7 are included to catch a design that changes outer chroma samples or ignores the upper codes. Random lines with negative deltas check the arithmetic shift, the tc clipping and the 0..255 saturation. A logical shift there would give wildly wrong p0 and q0 values.

// File: rtl/dbf_pkg.sv
// Package dbf_pkg: widths, stage types and arithmetic helpers for the edge filter.
// Assumes 8-bit samples; work width leaves headroom for the widest tap sum.
package dbf_pkg;
    localparam int PW  = 8;          // sample width
    localparam int NS  = 8;          // samples per line
    localparam int LW  = PW * NS;    // line width
    localparam int CW  = 5;          // C1 width
    localparam int TW  = CW + 1;     // tc width
    localparam int SW  = PW + 4;     // signed work width
    localparam int BW  = 3;          // strength code width

    typedef logic [PW-1:0]        pix_t;
    typedef logic signed [SW-1:0] sw_t;

    // first member sits at the MSB, so q3 is the top byte and p3 the bottom
    typedef struct packed {
        pix_t q3, q2, q1, q0, p0, p1, p2, p3;
    } line_t;

    typedef enum logic [1:0] {M_PASS = 2'd0, M_NORM = 2'd1, M_STRONG = 2'd2} mode_t;

    typedef struct packed {
        logic            v;
        line_t           ln;
        logic [BW-1:0]   bs;
        pix_t            alpha;
        pix_t            beta;
        logic [CW-1:0]   c1;
        logic            ch;
    } st1_t;

    typedef struct packed {
        logic            v;
        line_t           ln;
        mode_t           mode;
        logic            ch;
        logic            ap;
        logic            aq;
        logic            bp;
        logic            bq;
        logic [CW-1:0]   c1;
        logic [TW-1:0]   tc;
    } st2_t;

    typedef struct packed {
        sw_t t1;    // x1 + p0 + q0
        sw_t t2;    // x2 + t1
        sw_t s32;   // 2*(x3 + x2)
        sw_t w;     // 2*x1 + x0 + y1
        sw_t n1;    // x2 + ((p0+q0+1)>>1) - 2*x1
    } side_pre_t;

    typedef struct packed {
        st2_t      c;
        sw_t       dr;
        side_pre_t pp;
        side_pre_t pq;
    } st3_t;

    typedef struct packed {
        logic  v;
        line_t ln;
    } st4_t;

    function automatic pix_t absd(pix_t a, pix_t b);
        return (a > b) ? a - b : b - a;
    endfunction

    function automatic sw_t ext(pix_t a);
        return sw_t'({{(SW-PW){1'b0}}, a});
    endfunction

    function automatic pix_t sat(sw_t v);
        if (v < 0)                         return '0;
        else if (v > ext({PW{1'b1}}))      return '1;
        else                               return v[PW-1:0];
    endfunction

    function automatic sw_t clip_s(sw_t v, logic [TW-1:0] lim);
        sw_t l;
        l = sw_t'({{(SW-TW){1'b0}}, lim});
        if (v > l)       return l;
        else if (v < -l) return -l;
        else             return v;
    endfunction

    function automatic pix_t lo(sw_t v);
        return v[PW-1:0];
    endfunction
endpackage

// File: rtl/dbf_decide.sv
// dbf_decide: threshold decision for one line (stage 2 logic).
// Picks pass/normal/strong mode, the per-side flatness flags, the per-side
// strong-filter enables and the clipping bound tc. Purely combinational.
module dbf_decide
    import dbf_pkg::*;
(
    input  line_t          ln,
    input  logic [BW-1:0]  bs,
    input  pix_t           alpha,
    input  pix_t           beta,
    input  logic [CW-1:0]  c1,
    input  logic           ch,
    output mode_t          mode,
    output logic           ap,
    output logic           aq,
    output logic           bp,
    output logic           bq,
    output logic [TW-1:0]  tc
);
    logic           gate;
    logic           near;
    logic [PW:0]    near_lim;

    // gradient gate and per-side flatness tests
    always_comb begin
        gate = (bs != '0) && (absd(ln.p0, ln.q0) < alpha)
            && (absd(ln.p1, ln.p0) < beta) && (absd(ln.q1, ln.q0) < beta);
        ap = absd(ln.p2, ln.p0) < beta;
        aq = absd(ln.q2, ln.q0) < beta;
        near_lim = {1'b0, alpha >> 2} + (PW+1)'(2);
        near = {1'b0, absd(ln.p0, ln.q0)} < near_lim;
    end

    // mode selection; codes 4 and above mean strong
    always_comb begin
        if (!gate)                    mode = M_PASS;
        else if (bs >= BW'(4))        mode = M_STRONG;
        else                          mode = M_NORM;
    end

    // strong full-filter enables are luma-only and per side
    always_comb begin
        bp = !ch && ap && near;
        bq = !ch && aq && near;
    end

    // clipping bound: chroma adds one, luma adds one per flat side
    always_comb begin
        if (ch) tc = {1'b0, c1} + TW'(1);
        else    tc = {1'b0, c1} + TW'(ap) + TW'(aq);
    end
endmodule

// File: rtl/dbf_side_pre.sv
// dbf_side_pre: pre-filter partial sums for one side of the edge (stage 3).
// x0..x3 are the own-side samples from the edge outward, y1 the second
// sample across the edge, pq = p0+q0 shared by both sides. Combinational.
module dbf_side_pre
    import dbf_pkg::*;
(
    input  pix_t       x0,
    input  pix_t       x1,
    input  pix_t       x2,
    input  pix_t       x3,
    input  pix_t       y1,
    input  sw_t        pq,
    output side_pre_t  pre
);
    sw_t half;

    // two-input adder chain; t1 and t2 feed several taps downstream
    always_comb begin
        half    = (pq + sw_t'(1)) >>> 1;
        pre.t1  = ext(x1) + pq;
        pre.t2  = ext(x2) + pre.t1;
        pre.s32 = (ext(x3) + ext(x2)) <<< 1;
        pre.w   = (ext(x1) <<< 1) + ext(x0) + ext(y1);
        pre.n1  = ext(x2) + half - (ext(x1) <<< 1);
    end
endmodule

// File: rtl/dbf_side_post.sv
// dbf_side_post: secondary filter for one side (stage 4).
// Finishes the taps from the shared partial sums and selects the new
// x0..x2. NEG=1 for the far side, where delta is subtracted. Combinational.
module dbf_side_post
    import dbf_pkg::*;
#(
    parameter bit NEG = 1'b0
) (
    input  mode_t          mode,
    input  logic           ch,
    input  logic           big,
    input  logic           flat,
    input  logic [CW-1:0]  c1,
    input  logic [TW-1:0]  tc,
    input  sw_t            dr,
    input  side_pre_t      pre,
    input  pix_t           x0,
    input  pix_t           x1,
    input  pix_t           x2,
    input  pix_t           y1,
    output pix_t           nx0,
    output pix_t           nx1,
    output pix_t           nx2
);
    sw_t d;
    sw_t d1;

    // clipped deltas for the normal filter
    always_comb begin
        d  = clip_s(dr, tc);
        if (NEG) d = -d;
        d1 = clip_s(pre.n1 >>> 1, {1'b0, c1});
    end

    // output select per mode
    always_comb begin
        nx0 = x0;
        nx1 = x1;
        nx2 = x2;
        case (mode)
            M_NORM: begin
                nx0 = sat(ext(x0) + d);
                if (!ch && flat) nx1 = sat(ext(x1) + d1);
            end
            M_STRONG: begin
                if (big) begin
                    nx0 = lo((pre.t2 + pre.t1 + ext(y1) + sw_t'(4)) >>> 3);
                    nx1 = lo((pre.t2 + sw_t'(2)) >>> 2);
                    nx2 = lo((pre.s32 + pre.t2 + sw_t'(4)) >>> 3);
                end else begin
                    nx0 = lo((pre.w + sw_t'(2)) >>> 2);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbf_edge_pipe.sv
// dbf_edge_pipe: five-stage deblocking filter for one edge line per clock.
// Stages: capture, decision, pre-filter, secondary filter, write-back.
// Assumes alpha/beta/C1 come from external tables; no stalls, no backpressure.
module dbf_edge_pipe
    import dbf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [LW-1:0]       in_line,
    input  logic [BW-1:0]       in_bs,
    input  logic [PW-1:0]       in_alpha,
    input  logic [PW-1:0]       in_beta,
    input  logic [CW-1:0]       in_c1,
    input  logic                in_chroma,
    output logic                out_valid,
    output logic [LW-1:0]       out_line
);
    st1_t s1;
    st2_t s2, s2_d;
    st3_t s3;
    st4_t s4, s4_d;
    st4_t s5;

    mode_t         dmode;
    logic          dap, daq, dbp, dbq;
    logic [TW-1:0] dtc;

    // stage 1: capture the incoming line and its parameters
    always_ff @(posedge clk) begin
        if (!rst_n) s1 <= '0;
        else begin
            s1.v     <= in_valid;
            s1.ln    <= line_t'(in_line);
            s1.bs    <= in_bs;
            s1.alpha <= in_alpha;
            s1.beta  <= in_beta;
            s1.c1    <= in_c1;
            s1.ch    <= in_chroma;
        end
    end

    dbf_decide u_dec (
        .ln(s1.ln), .bs(s1.bs), .alpha(s1.alpha), .beta(s1.beta),
        .c1(s1.c1), .ch(s1.ch), .mode(dmode), .ap(dap), .aq(daq),
        .bp(dbp), .bq(dbq), .tc(dtc)
    );

    // stage 2 next-state assembly
    always_comb begin
        s2_d      = '0;
        s2_d.v    = s1.v;
        s2_d.ln   = s1.ln;
        s2_d.mode = dmode;
        s2_d.ch   = s1.ch;
        s2_d.ap   = dap;
        s2_d.aq   = daq;
        s2_d.bp   = dbp;
        s2_d.bq   = dbq;
        s2_d.c1   = s1.c1;
        s2_d.tc   = dtc;
    end

    // stage 2: register the decision
    always_ff @(posedge clk) begin
        if (!rst_n) s2 <= '0;
        else        s2 <= s2_d;
    end

    // stage 3 shared terms
    sw_t       pq_sum;
    sw_t       dr_raw;
    side_pre_t pre_p, pre_q;

    // shared edge sum and raw normal-filter delta
    always_comb begin
        pq_sum = ext(s2.ln.p0) + ext(s2.ln.q0);
        dr_raw = (((ext(s2.ln.q0) - ext(s2.ln.p0)) <<< 2)
                 + ext(s2.ln.p1) - ext(s2.ln.q1) + sw_t'(4)) >>> 3;
    end

    // per-side views of the line for pre and post stages: index 0 = p, 1 = q
    pix_t      ax0 [2], ax1 [2], ax2 [2], ax3 [2], ay1 [2];
    pix_t      bx0 [2], bx1 [2], bx2 [2], by1 [2];
    pix_t      nx0 [2], nx1 [2], nx2 [2];
    side_pre_t pre_a [2];

    // side mapping of stage-2 and stage-3 samples
    always_comb begin
        ax0[0] = s2.ln.p0; ax1[0] = s2.ln.p1; ax2[0] = s2.ln.p2; ax3[0] = s2.ln.p3; ay1[0] = s2.ln.q1;
        ax0[1] = s2.ln.q0; ax1[1] = s2.ln.q1; ax2[1] = s2.ln.q2; ax3[1] = s2.ln.q3; ay1[1] = s2.ln.p1;
        bx0[0] = s3.c.ln.p0; bx1[0] = s3.c.ln.p1; bx2[0] = s3.c.ln.p2; by1[0] = s3.c.ln.q1;
        bx0[1] = s3.c.ln.q0; bx1[1] = s3.c.ln.q1; bx2[1] = s3.c.ln.q2; by1[1] = s3.c.ln.p1;
    end

    for (genvar g = 0; g < 2; g++) begin : g_side
        dbf_side_pre u_pre (
            .x0(ax0[g]), .x1(ax1[g]), .x2(ax2[g]), .x3(ax3[g]), .y1(ay1[g]),
            .pq(pq_sum), .pre(pre_a[g])
        );
        dbf_side_post #(.NEG(g == 1)) u_post (
            .mode(s3.c.mode), .ch(s3.c.ch),
            .big((g == 0) ? s3.c.bp : s3.c.bq),
            .flat((g == 0) ? s3.c.ap : s3.c.aq),
            .c1(s3.c.c1), .tc(s3.c.tc), .dr(s3.dr),
            .pre((g == 0) ? s3.pp : s3.pq),
            .x0(bx0[g]), .x1(bx1[g]), .x2(bx2[g]), .y1(by1[g]),
            .nx0(nx0[g]), .nx1(nx1[g]), .nx2(nx2[g])
        );
    end

    assign pre_p = pre_a[0];
    assign pre_q = pre_a[1];

    // stage 3: register partial sums with the decision
    always_ff @(posedge clk) begin
        if (!rst_n) s3 <= '0;
        else begin
            s3.c  <= s2;
            s3.dr <= dr_raw;
            s3.pp <= pre_p;
            s3.pq <= pre_q;
        end
    end

    // stage 4 next-state: reassemble the line from side results
    always_comb begin
        s4_d       = '0;
        s4_d.v     = s3.c.v;
        s4_d.ln    = s3.c.ln;
        s4_d.ln.p0 = nx0[0];
        s4_d.ln.p1 = nx1[0];
        s4_d.ln.p2 = nx2[0];
        s4_d.ln.q0 = nx0[1];
        s4_d.ln.q1 = nx1[1];
        s4_d.ln.q2 = nx2[1];
    end

    // stage 4: register the filtered line
    always_ff @(posedge clk) begin
        if (!rst_n) s4 <= '0;
        else        s4 <= s4_d;
    end

    // stage 5: write-back register driving the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) s5 <= '0;
        else        s5 <= s4;
    end

    assign out_valid = s5.v;
    assign out_line  = s5.ln;

    // assertions on the port-level contract
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##5 out_valid);

    a_r9_outer_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##5 (out_line[PW-1:0] == $past(in_line[PW-1:0], 5)
                      && out_line[LW-1:LW-PW] == $past(in_line[LW-1:LW-PW], 5)));

    a_r1_bs0_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bs == '0) |-> ##5 (out_line == $past(in_line, 5)));

    a_r8_chroma_outer: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_chroma) |-> ##5
            (out_line[3*PW-1:0] == $past(in_line[3*PW-1:0], 5)
          && out_line[LW-1:5*PW] == $past(in_line[LW-1:5*PW], 5)));

    a_r4_third_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bs != '0 && in_bs < BW'(4)) |-> ##5
            (out_line[2*PW-1:PW] == $past(in_line[2*PW-1:PW], 5)
          && out_line[7*PW-1:6*PW] == $past(in_line[7*PW-1:6*PW], 5)));

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_line == '0));
endmodule

// File: tb/sim_dbf_edge_pipe.sv
`timescale 1ns/1ps
module sim_dbf_edge_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_line = '0;
    logic [2:0]  in_bs = '0;
    logic [7:0]  in_alpha = '0;
    logic [7:0]  in_beta = '0;
    logic [4:0]  in_c1 = '0;
    logic        in_chroma = 1'b0;
    logic        out_valid;
    logic [63:0] out_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int NRAND = 3000;
    localparam int NDIR  = 10;
    localparam int NTOT  = NDIR + NRAND;

    logic [63:0] exp_l [NTOT+8];
    bit          exp_v [NTOT+8];
    string       exp_t [NTOT+8];

    always #2.5 clk = ~clk;

    dbf_edge_pipe u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line),
        .in_bs(in_bs), .in_alpha(in_alpha), .in_beta(in_beta), .in_c1(in_c1),
        .in_chroma(in_chroma), .out_valid(out_valid), .out_line(out_line)
    );

    function automatic int iabs(int a);
        return (a < 0) ? -a : a;
    endfunction

    function automatic int clip3(int lo_v, int hi_v, int v);
        return (v < lo_v) ? lo_v : ((v > hi_v) ? hi_v : v);
    endfunction

    function automatic logic [63:0] mk(int a3, int a2, int a1, int a0,
                                       int b0, int b1, int b2, int b3);
        logic [63:0] r;
        r = {b3[7:0], b2[7:0], b1[7:0], b0[7:0], a0[7:0], a1[7:0], a2[7:0], a3[7:0]};
        return r;
    endfunction

    // reference model written from the requirements
    function automatic logic [63:0] ref_f(logic [63:0] ln, int bs, int al, int be,
                                          int c1, bit ch);
        int p[4]; int q[4]; int rp[4]; int rq[4];
        int tc, d;
        bit gate, ap, aq, nr;
        for (int k = 0; k < 4; k++) begin
            p[k] = int'(ln[8*(3-k) +: 8]);
            q[k] = int'(ln[8*(4+k) +: 8]);
            rp[k] = p[k]; rq[k] = q[k];
        end
        gate = bs != 0 && iabs(p[0]-q[0]) < al && iabs(p[1]-p[0]) < be && iabs(q[1]-q[0]) < be;
        ap = iabs(p[2]-p[0]) < be;
        aq = iabs(q[2]-q[0]) < be;
        nr = iabs(p[0]-q[0]) < ((al >> 2) + 2);
        if (gate) begin
            if (bs >= 4) begin
                if (!ch && ap && nr) begin
                    rp[0] = (p[2] + 2*p[1] + 2*p[0] + 2*q[0] + q[1] + 4) >> 3;
                    rp[1] = (p[2] + p[1] + p[0] + q[0] + 2) >> 2;
                    rp[2] = (2*p[3] + 3*p[2] + p[1] + p[0] + q[0] + 4) >> 3;
                end else rp[0] = (2*p[1] + p[0] + q[1] + 2) >> 2;
                if (!ch && aq && nr) begin
                    rq[0] = (q[2] + 2*q[1] + 2*q[0] + 2*p[0] + p[1] + 4) >> 3;
                    rq[1] = (q[2] + q[1] + q[0] + p[0] + 2) >> 2;
                    rq[2] = (2*q[3] + 3*q[2] + q[1] + q[0] + p[0] + 4) >> 3;
                end else rq[0] = (2*q[1] + q[0] + p[1] + 2) >> 2;
            end else begin
                tc = ch ? c1 + 1 : c1 + int'(ap) + int'(aq);
                d = clip3(-tc, tc, ((q[0]-p[0])*4 + (p[1]-q[1]) + 4) >>> 3);
                rp[0] = clip3(0, 255, p[0] + d);
                rq[0] = clip3(0, 255, q[0] - d);
                if (!ch && ap)
                    rp[1] = p[1] + clip3(-c1, c1, (p[2] + ((p[0]+q[0]+1) >> 1) - 2*p[1]) >>> 1);
                if (!ch && aq)
                    rq[1] = q[1] + clip3(-c1, c1, (q[2] + ((p[0]+q[0]+1) >> 1) - 2*q[1]) >>> 1);
            end
        end
        return mk(rp[3], rp[2], rp[1], rp[0], rq[0], rq[1], rq[2], rq[3]);
    endfunction

    function automatic string tag_of(logic [63:0] ln, int bs, int al, int be, bit ch);
        int p0, p1, q0, q1;
        p0 = int'(ln[31:24]); p1 = int'(ln[23:16]);
        q0 = int'(ln[39:32]); q1 = int'(ln[47:40]);
        if (bs == 0) return "R1";
        if (!(iabs(p0-q0) < al && iabs(p1-p0) < be && iabs(q1-q0) < be)) return "R2";
        if (ch) return "R8";
        if (bs > 4) return "R10";
        if (bs == 4) return "R6 R7";
        return "R3 R4 R5";
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic drive(int idx, bit v, logic [63:0] ln, int bs, int al, int be,
                         int c1, bit ch);
        in_valid  = v;
        in_line   = ln;
        in_bs     = bs[2:0];
        in_alpha  = al[7:0];
        in_beta   = be[7:0];
        in_c1     = c1[4:0];
        in_chroma = ch;
        exp_v[idx] = v;
        exp_l[idx] = ref_f(ln, bs, al, be, c1, ch);
        exp_t[idx] = tag_of(ln, bs, al, be, ch);
    endtask

    task automatic drive_dir(int i);
        case (i)
            0: drive(i, 1, mk(60,62,64,66,70,72,74,76), 0, 40, 10, 9, 0);   // R1 passthrough
            1: drive(i, 1, mk(60,62,64,66,96,97,98,99), 2, 30, 10, 9, 0);   // R2 |p0-q0| == alpha
            2: drive(i, 1, mk(60,62,64,66,70,80,81,82), 2, 40, 10, 9, 0);   // R2 |q1-q0| == beta
            3: drive(i, 1, mk(80,82,84,86,90,92,94,96), 4, 40, 10, 9, 0);   // R6 both sides flat
            4: drive(i, 1, mk(80,82,84,86,90,92,120,96), 4, 40, 10, 9, 0);  // R7 q side rough
            5: drive(i, 1, mk(80,82,84,86,90,92,94,96), 3, 40, 10, 4, 1);   // R8 normal chroma
            6: drive(i, 1, mk(80,82,84,86,90,92,94,96), 4, 40, 10, 4, 1);   // R8 strong chroma
            7: drive(i, 1, mk(80,82,84,86,90,92,94,96), 6, 40, 10, 4, 0);   // R10 code 6
            8: drive(i, 1, mk(10,30,200,205,195,190,170,150), 1, 20, 8, 3, 0); // R3 R5 neg delta
            default: drive(i, 0, mk(1,2,3,4,5,6,7,8), 4, 40, 10, 4, 0);      // R9 bubble
        endcase
    endtask

    task automatic drive_rand(int i);
        int base, al, be, c1, bs, vv;
        int s[8];
        bit ch;
        base = int'($urandom_range(20, 235));
        for (int k = 0; k < 8; k++) s[k] = base + int'($urandom_range(0, 14)) - 7;
        if ($urandom_range(0, 9) == 0) s[3] = s[3] + 25;
        al = int'($urandom_range(4, 60));
        be = int'($urandom_range(2, 20));
        c1 = int'($urandom_range(0, 25));
        bs = int'($urandom_range(0, 7));
        ch = 1'($urandom_range(0, 1));
        vv = int'($urandom_range(0, 9));
        drive(i, vv != 0, mk(s[0], s[1], s[2], s[3], s[4], s[5], s[6], s[7]), bs, al, be, c1, ch);
    endtask

    // watchdog: a hang counts as a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_line == '0, "R11", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NTOT + 6; cyc++) begin
            if (cyc >= 5) begin
                chk(out_valid == exp_v[cyc-5], "R9", {63'd0, out_valid}, {63'd0, exp_v[cyc-5]});
                if (exp_v[cyc-5]) chk(out_line == exp_l[cyc-5], exp_t[cyc-5], out_line, exp_l[cyc-5]);
            end else begin
                chk(out_valid == 1'b0, "R9", {63'd0, out_valid}, 64'd0);
            end
            if (cyc < NDIR)      drive_dir(cyc);
            else if (cyc < NTOT) drive_rand(cyc);
            else                 in_valid = 1'b0;
            @(negedge clk);
        end
        // mid-stream reset clears the write-back register
        drive(0, 1, mk(80,82,84,86,90,92,94,96), 4, 40, 10, 9, 0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_line == '0, "R11", out_line, 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule